// File: doc/BRIEF.md
# Load Current Digitizer with Full-Scale Alert

This block turns a load-current monitor voltage into an 8-bit reading. An upstream converter supplies the monitor voltage as an unsigned millivolt code on a plain input bus. A free-running timer marks a capture instant once per sample period; the default is 16500 clock cycles, which is 132 µs at 125 MHz. At each capture instant the block scales the millivolt value linearly onto 0..255, with 900 mV as full scale, and stores the result. Between capture instants the stored reading does not change.

Two protection outputs come from the same capture. An active-low alert is driven low while the stored reading sits at full scale (FFh), and it is released at the first capture that gives a smaller value. A separate, higher threshold of 1120 mV raises a one-cycle overcurrent-trip pulse, which a shutdown sequencer downstream can latch.

Firmware reads the stored value through a small synchronous read port at register address 15h. The reading is also available directly as an output bus.

Top module: `imon_digitizer`

## Requirements
- R1: While reset is high and in the first cycle after it, `reading` is 00h, `alert_n` is 1, `oc_trip` is 0 and `rd_data` is 00h.
- R2: The first capture happens on the SAMPLE_CYCLES-th rising edge after reset is released, and a capture follows every SAMPLE_CYCLES edges after that. `reading` changes only on a capture edge and holds its value between captures.
- R3: For a captured input below 900 mV, `reading` equals floor(mon_mv × 255 / 900). For example, 899 mV gives 254 and 450 mV gives 127.
- R4: For a captured input at or above 900 mV, up to the largest 12-bit code, `reading` is FFh.
- R5: Following a capture that stores FFh, `alert_n` is 0, and it stays 0 through every later capture that also stores FFh.
- R6: `alert_n` returns to 1 on the first capture that stores a value below FFh, and stays 1 until a capture stores FFh again.
- R7: `oc_trip` is 1 for exactly the one cycle after a capture at which mon_mv is strictly greater than 1120 mV. A capture at exactly 1120 mV produces no pulse, and `oc_trip` is 0 at all other times.
- R8: When `rd_en` is 1 with `rd_addr` = 15h, `rd_data` shows the value `reading` had at that edge on the following cycle. When `rd_en` is 1 with any other address, `rd_data` becomes 00h. When `rd_en` is 0, `rd_data` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mon_mv | input | 12 | Monitor voltage in millivolts, unsigned |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Registered read data |
| reading | output | 8 | Stored current reading |
| alert_n | output | 1 | Full-scale alert, active low |
| oc_trip | output | 1 | One-cycle overcurrent-trip pulse |

## Verification
The hardest situation to reach from the ports is an input that changes between captures. The stored value has to ignore that change until the next capture edge, and the trip pulse has to be attributed to the correct capture. To get there, the bench is built with a short sample period and tracks the capture phase from reset, so it knows where each capture edge falls. It drives a new input immediately after each capture and checks that the reading is unchanged one cycle later. It sweeps every millivolt value from 0 to 1250 plus the largest code, then descends across the trip and full-scale thresholds to exercise the alert release.

// File: rtl/imon_pkg.sv
package imon_pkg;

    localparam int MV_W_DEF      = 12;
    localparam int CODE_W_DEF    = 8;
    localparam int FULL_MV_DEF   = 900;
    localparam int TRIP_MV_DEF   = 1120;
    localparam int PERIOD_DEF    = 16500;
    localparam int ADDR_W_DEF    = 8;
    localparam int READ_ADDR_DEF = 'h15;

    typedef struct packed {
        logic [7:0] code;
        logic       full;
        logic       over;
    } imon_sample_t;

    function automatic logic [7:0] scale_mv(input int mv, input int full_mv, input int code_max);
        int prod;
        if (mv >= full_mv) begin
            return 8'(code_max);
        end
        prod = mv * code_max;
        return 8'(prod / full_mv);
    endfunction

endpackage

// File: rtl/imon_timer.sv
module imon_timer #(
    parameter int PERIOD = 16500
) (
    input  logic clk,
    input  logic rst,
    output logic strobe
);
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    generate
        if (PERIOD <= 1) begin : g_every
            assign strobe = 1'b1;
        end else begin : g_count
            logic [CNT_W-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt <= '0;
                end else if (cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign strobe = (cnt == LAST);

            // R2
            single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
                strobe |=> !strobe);
        end
    endgenerate

endmodule

// File: rtl/imon_quant.sv
module imon_quant
    import imon_pkg::*;
#(
    parameter int MV_W    = MV_W_DEF,
    parameter int CODE_W  = CODE_W_DEF,
    parameter int FULL_MV = FULL_MV_DEF,
    parameter int TRIP_MV = TRIP_MV_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            strobe,
    input  logic [MV_W-1:0] mon_mv,
    output imon_sample_t    cur,
    output logic [7:0]      reading
);
    localparam int CODE_MAX = (1 << CODE_W) - 1;

    int mv_int;

    always_comb begin
        mv_int   = int'(mon_mv);
        cur.code = scale_mv(mv_int, FULL_MV, CODE_MAX);
        cur.full = (mv_int >= FULL_MV);
        cur.over = (mv_int > TRIP_MV);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reading <= '0;
        end else if (strobe) begin
            reading <= cur.code;
        end
    end

    // R2
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(strobe) |-> $stable(reading));

    // R4
    sat_code_chk: assert property (@(posedge clk) disable iff (rst)
        cur.full |-> cur.code == 8'(CODE_MAX));

endmodule

// File: rtl/imon_fault.sv
module imon_fault
    import imon_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe,
    input  imon_sample_t cur,
    output logic         alert_n,
    output logic         oc_trip
);

    always_ff @(posedge clk) begin
        if (rst) begin
            alert_n <= 1'b1;
            oc_trip <= 1'b0;
        end else begin
            oc_trip <= strobe && cur.over;
            if (strobe) begin
                alert_n <= !cur.full;
            end
        end
    end

    // R7
    trip_after_capture_chk: assert property (@(posedge clk) disable iff (rst)
        oc_trip |-> $past(strobe));

    // R6
    alert_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(strobe) |-> $stable(alert_n));

endmodule

// File: rtl/imon_regport.sv
module imon_regport #(
    parameter int ADDR_W    = 8,
    parameter int READ_ADDR = 'h15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        reading,
    output logic [7:0]        rd_data
);
    localparam logic [ADDR_W-1:0] HIT = ADDR_W'(READ_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= (rd_addr == HIT) ? reading : 8'h00;
        end
    end

    // R8
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en) && $past(rd_addr) != HIT) |-> rd_data == 8'h00);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_en) |-> $stable(rd_data));

endmodule

// File: rtl/imon_digitizer.sv
module imon_digitizer
    import imon_pkg::*;
#(
    parameter int SAMPLE_CYCLES = PERIOD_DEF,
    parameter int MV_W          = MV_W_DEF,
    parameter int FULL_MV       = FULL_MV_DEF,
    parameter int TRIP_MV       = TRIP_MV_DEF,
    parameter int ADDR_W        = ADDR_W_DEF,
    parameter int READ_ADDR     = READ_ADDR_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MV_W-1:0]   mon_mv,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [7:0]        reading,
    output logic              alert_n,
    output logic              oc_trip
);
    logic         strobe;
    imon_sample_t cur;

    imon_timer #(.PERIOD(SAMPLE_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe)
    );

    imon_quant #(
        .MV_W    (MV_W),
        .CODE_W  (8),
        .FULL_MV (FULL_MV),
        .TRIP_MV (TRIP_MV)
    ) u_quant (
        .clk     (clk),
        .rst     (rst),
        .strobe  (strobe),
        .mon_mv  (mon_mv),
        .cur     (cur),
        .reading (reading)
    );

    imon_fault u_fault (
        .clk     (clk),
        .rst     (rst),
        .strobe  (strobe),
        .cur     (cur),
        .alert_n (alert_n),
        .oc_trip (oc_trip)
    );

    imon_regport #(
        .ADDR_W    (ADDR_W),
        .READ_ADDR (READ_ADDR)
    ) u_regport (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .reading (reading),
        .rd_data (rd_data)
    );

    // R5
    alert_at_full_chk: assert property (@(posedge clk) disable iff (rst)
        reading == 8'hFF |-> !alert_n);

    // R6
    release_below_chk: assert property (@(posedge clk) disable iff (rst)
        reading != 8'hFF |-> alert_n);

    // R7
    trip_saturated_chk: assert property (@(posedge clk) disable iff (rst)
        oc_trip |-> reading == 8'hFF);

endmodule

// File: tb/sim_imon_digitizer.sv
`timescale 1ns/1ps
module sim_imon_digitizer;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mon_mv = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [7:0]  rd_data, reading;
    logic        alert_n, oc_trip;

    int total = 0;
    int bad = 0;
    int exp_read = 0;
    int exp_alert = 1;
    int exp_rd = 0;

    always #4 clk = ~clk;

    imon_digitizer #(.SAMPLE_CYCLES(P)) u0 (
        .clk(clk), .rst(rst), .mon_mv(mon_mv), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .reading(reading), .alert_n(alert_n), .oc_trip(oc_trip)
    );

    task automatic chk(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (mv=%0d t=%0t)", req, act, expv, mon_mv, $time);
        end
    endtask

    // one sample window: starts and ends at a negedge just after a capture
    task automatic window(input int mv, input bit do_read, input int addr);
        int code;
        mon_mv  = 12'(mv);
        rd_en   = do_read;
        rd_addr = 8'(addr);
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        if (do_read) exp_rd = (addr == 'h15) ? exp_read : 0;
        chk("R8 rd_data", int'(rd_data), exp_rd);
        chk("R2 hold", int'(reading), exp_read);
        repeat (P - 2) @(posedge clk);
        @(negedge clk);
        chk("R7 no pulse", int'(oc_trip), 0);
        @(posedge clk);
        @(negedge clk);
        code = (mv >= 900) ? 255 : (mv * 255) / 900;
        exp_read  = code;
        exp_alert = (code == 255) ? 0 : 1;
        if (mv >= 900) chk("R4 saturate", int'(reading), code);
        else           chk("R3 scale", int'(reading), code);
        if (exp_alert == 0) chk("R5 alert", int'(alert_n), 0);
        else                chk("R6 release", int'(alert_n), 1);
        chk("R7 trip", int'(oc_trip), (mv > 1120) ? 1 : 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reading", int'(reading), 0);
        chk("R1 alert_n", int'(alert_n), 1);
        chk("R1 oc_trip", int'(oc_trip), 0);
        chk("R1 rd_data", int'(rd_data), 0);
        rst = 1'b0;
        for (int mv = 0; mv <= 1250; mv++) begin
            window(mv, (mv % 3) != 2, ((mv % 3) == 1) ? 'h14 : 'h15);
        end
        window(4095, 1'b1, 'h15);
        window(4095, 1'b1, 'h15);
        window(1121, 1'b0, 0);
        window(1120, 1'b1, 'h15);
        window(900, 1'b0, 0);
        window(899, 1'b1, 'h15);
        window(450, 1'b1, 'h15);
        window(1500, 1'b1, 'h00);
        window(0, 1'b1, 'h15);
        window(0, 1'b1, 'h15);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule